// File: doc/BRIEF.md
# Power-Safe Record Append Sequencer

This block appends one record to the end of the record list in the active block of a flash-based non-volatile store. It turns one request into a fixed series of single-word program commands. The order of that series lets an interrupted append never be mistaken for good data. A request carries the record identifier, the number of data words, the current end-of-list address and the first address past the active block. The data words arrive on a valid/ready stream. The commands leave on a word-programming port that answers each command with a done strobe and an optional failure flag.

Each record takes two metadata words and then its data words. The status word sits at the end-of-list address. The identifier/length word follows it, and the data words come after that. The status word is programmed twice. The first write sets it to a fixed "invalid" pattern, and the last write sets it to the "valid" pattern. Both writes only clear whole bit groups, so the error-correction parity of that word stays consistent. When the record does not fit, no write is issued and a block-swap request is raised instead.

Request stream rules: a request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while the sequencer is idle, and a request held while the sequencer is busy simply waits. Data stream rules: a word is consumed on an edge where `src_valid` and `src_ready` are both high. `src_ready` depends only on the sequencer's own state. The sequencer stalls without limit while `src_valid` is low, and the producer may hold or drop `src_valid` freely.

Top module: `rec_append_seq`

## Requirements
- R1: `req_ready` is 1 only when no record is in progress. It is 1 after reset. A request presented while busy is not taken and causes no program command.
- R2: A record of N data words fits when end-of-list + N + 2 <= block limit (word addresses). A request that does not fit issues no program command. It raises `swap_req` for exactly one cycle, in the cycle after acceptance, and leaves the sequencer idle.
- R3: For a fitting record at base address B, the commands go out in this order: status at B, then the identifier/length word at B+1, then data word i at B+2+i for i = 0..N-1 in stream order, then status at B again.
- R4: The first status write carries 0x0000FFFF and the last carries 0x00000000. The identifier/length word is {id[15:0], 8'h00, length[7:0]}. Any re-program of an already written word only clears whole 16-bit groups.
- R5: `pgm_start` is a single-cycle pulse. No new command starts until the port has returned `pgm_done` for the previous one.
- R6: `src_ready` is high only while the sequencer is waiting to launch a data-word command. A low `src_valid` stalls the sequence with no word skipped or repeated.
- R7: `pgm_done` with `pgm_fail` high stops the sequence at once. `rec_err` pulses for one cycle, no further command is issued, and the sequencer returns to idle.
- R8: After the final status write completes, `rec_done` pulses for one cycle with `new_eol` = B + N + 2.
- R9: A record with zero data words goes straight from the identifier/length write to the final status write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Append request present |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_id | input | ID_W | Record identifier |
| req_size | input | SIZE_W | Number of data words |
| eol_addr | input | ADDR_W | First erased word (end of list) |
| blk_limit | input | ADDR_W | First word address past the active block |
| src_valid | input | 1 | Data word present |
| src_ready | output | 1 | Data word accepted this cycle if valid |
| src_data | input | DATA_W | Data word |
| pgm_start | output | 1 | Program command strobe |
| pgm_addr | output | ADDR_W | Program word address |
| pgm_data | output | DATA_W | Program word value |
| pgm_done | input | 1 | Command finished |
| pgm_fail | input | 1 | Command failed, valid with pgm_done |
| swap_req | output | 1 | Not enough free space, block swap needed |
| rec_done | output | 1 | Record appended |
| rec_err | output | 1 | Append aborted by a program failure |
| new_eol | output | ADDR_W | End of list after the appended record |

## Verification
The main function is tried with records of three, zero, four and five data words. The port answers after one to three cycles, and the data stream sometimes has gaps every third cycle. Together these tell a correct fixed write order apart from one that skips or repeats a stream word, or that races ahead of the port's done strobe. The space check is tried at an exact fit, one word short, and with the end-of-list already past the limit, which catches an off-by-one in the comparison. Failures are injected on the identifier/length write and on the final status write, and a clean record follows. This shows that an abort leaves no trailing command and does not poison the next append. Requests held high during a busy record confirm that they are refused.

// File: rtl/rec_append_pkg.sv
package rec_append_pkg;

  // Which word of the record the sequencer is working on.
  typedef enum logic [1:0] {
    STEP_INV  = 2'd0,
    STEP_HDR  = 2'd1,
    STEP_DATA = 2'd2,
    STEP_VAL  = 2'd3
  } step_e;

  // Handshake phase with the program port.
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_ISSUE = 2'd1,
    PH_WAIT  = 2'd2
  } phase_e;

endpackage

// File: rtl/rec_space_check.sv
module rec_space_check #(
  parameter int ADDR_W     = 16,
  parameter int SIZE_W     = 8,
  parameter int META_WORDS = 2
) (
  input  logic [ADDR_W-1:0] eol,
  input  logic [ADDR_W-1:0] limit,
  input  logic [SIZE_W-1:0] size,
  output logic              fits
);
  // Two guard bits so the end address cannot wrap.
  localparam int XW = ADDR_W + 2;

  logic [XW-1:0] need_end;

  always_comb begin
    need_end = XW'(eol) + XW'(size) + XW'(META_WORDS);
    fits     = (need_end <= XW'(limit));
  end

endmodule

// File: rtl/rec_word_mux.sv
module rec_word_mux
  import rec_append_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 32,
  parameter int ID_W    = 16,
  parameter int SIZE_W  = 8,
  parameter int GROUP_W = 16
) (
  input  step_e             step,
  input  logic [ADDR_W-1:0] base,
  input  logic [ID_W-1:0]   rec_id,
  input  logic [SIZE_W-1:0] rec_size,
  input  logic [SIZE_W-1:0] idx,
  input  logic [DATA_W-1:0] src_data,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] data
);
  localparam int NGRP = DATA_W / GROUP_W;
  localparam int PADW = DATA_W - ID_W - SIZE_W;

  logic [DATA_W-1:0] inv_pat;
  logic [DATA_W-1:0] hdr_word;

  // Invalid pattern: upper half of the groups cleared, lower half erased.
  for (genvar g = 0; g < NGRP; g++) begin : g_inv
    if (g >= NGRP / 2) begin : g_clr
      assign inv_pat[g*GROUP_W +: GROUP_W] = {GROUP_W{1'b0}};
    end else begin : g_set
      assign inv_pat[g*GROUP_W +: GROUP_W] = {GROUP_W{1'b1}};
    end
  end

  assign hdr_word = {rec_id, {PADW{1'b0}}, rec_size};

  always_comb begin
    unique case (step)
      STEP_INV: begin
        addr = base;
        data = inv_pat;
      end
      STEP_HDR: begin
        addr = base + ADDR_W'(1);
        data = hdr_word;
      end
      STEP_DATA: begin
        addr = base + ADDR_W'(2) + ADDR_W'(idx);
        data = src_data;
      end
      default: begin
        addr = base;
        data = {DATA_W{1'b0}};
      end
    endcase
  end

endmodule

// File: rtl/rec_step_ctrl.sv
module rec_step_ctrl
  import rec_append_pkg::*;
#(
  parameter int SIZE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              fits,
  input  logic [SIZE_W-1:0] rec_size,
  input  logic              src_valid,
  input  logic              pgm_done,
  input  logic              pgm_fail,
  output logic              req_ready,
  output logic              accept,
  output logic              src_ready,
  output logic              issue,
  output logic              finish,
  output step_e             step,
  output logic [SIZE_W-1:0] idx,
  output logic              swap_req,
  output logic              rec_done,
  output logic              rec_err
);
  phase_e      phase;
  logic        port_ok;
  logic [SIZE_W-1:0] idx_nxt;

  always_comb begin
    req_ready = (phase == PH_IDLE);
    accept    = req_valid && req_ready;
    src_ready = (phase == PH_ISSUE) && (step == STEP_DATA);
    issue     = (phase == PH_ISSUE) && ((step != STEP_DATA) || src_valid);
    port_ok   = (phase == PH_WAIT) && pgm_done && !pgm_fail;
    finish    = port_ok && (step == STEP_VAL);
    idx_nxt   = idx + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      step     <= STEP_INV;
      idx      <= '0;
      swap_req <= 1'b0;
      rec_done <= 1'b0;
      rec_err  <= 1'b0;
    end else begin
      swap_req <= 1'b0;
      rec_done <= 1'b0;
      rec_err  <= 1'b0;
      unique case (phase)
        PH_IDLE: begin
          if (accept) begin
            if (fits) begin
              phase <= PH_ISSUE;
              step  <= STEP_INV;
              idx   <= '0;
            end else begin
              swap_req <= 1'b1;
            end
          end
        end
        PH_ISSUE: begin
          if (issue) begin
            phase <= PH_WAIT;
          end
        end
        PH_WAIT: begin
          if (pgm_done) begin
            if (pgm_fail) begin
              rec_err <= 1'b1;
              phase   <= PH_IDLE;
            end else begin
              unique case (step)
                STEP_INV: begin
                  step  <= STEP_HDR;
                  phase <= PH_ISSUE;
                end
                STEP_HDR: begin
                  step  <= (rec_size == '0) ? STEP_VAL : STEP_DATA;
                  phase <= PH_ISSUE;
                end
                STEP_DATA: begin
                  idx   <= idx_nxt;
                  step  <= (idx_nxt == rec_size) ? STEP_VAL : STEP_DATA;
                  phase <= PH_ISSUE;
                end
                default: begin
                  rec_done <= 1'b1;
                  phase    <= PH_IDLE;
                end
              endcase
            end
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/rec_append_seq.sv
module rec_append_seq
  import rec_append_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 32,
  parameter int ID_W    = 16,
  parameter int SIZE_W  = 8,
  parameter int GROUP_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ID_W-1:0]   req_id,
  input  logic [SIZE_W-1:0] req_size,
  input  logic [ADDR_W-1:0] eol_addr,
  input  logic [ADDR_W-1:0] blk_limit,
  input  logic              src_valid,
  output logic              src_ready,
  input  logic [DATA_W-1:0] src_data,
  output logic              pgm_start,
  output logic [ADDR_W-1:0] pgm_addr,
  output logic [DATA_W-1:0] pgm_data,
  input  logic              pgm_done,
  input  logic              pgm_fail,
  output logic              swap_req,
  output logic              rec_done,
  output logic              rec_err,
  output logic [ADDR_W-1:0] new_eol
);
  localparam int META_WORDS = 2;

  logic              fits;
  logic              accept;
  logic              issue;
  logic              finish;
  step_e             step;
  logic [SIZE_W-1:0] idx;
  logic [ADDR_W-1:0] base_q;
  logic [ID_W-1:0]   id_q;
  logic [SIZE_W-1:0] size_q;
  logic [ADDR_W-1:0] word_addr;
  logic [DATA_W-1:0] word_data;

  rec_space_check #(
    .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .META_WORDS(META_WORDS)
  ) u_space (
    .eol(eol_addr), .limit(blk_limit), .size(req_size), .fits(fits)
  );

  rec_step_ctrl #(.SIZE_W(SIZE_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .fits(fits),
    .rec_size(size_q), .src_valid(src_valid), .pgm_done(pgm_done),
    .pgm_fail(pgm_fail), .req_ready(req_ready), .accept(accept),
    .src_ready(src_ready), .issue(issue), .finish(finish), .step(step),
    .idx(idx), .swap_req(swap_req), .rec_done(rec_done), .rec_err(rec_err)
  );

  rec_word_mux #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_W(ID_W), .SIZE_W(SIZE_W),
    .GROUP_W(GROUP_W)
  ) u_mux (
    .step(step), .base(base_q), .rec_id(id_q), .rec_size(size_q),
    .idx(idx), .src_data(src_data), .addr(word_addr), .data(word_data)
  );

  // Request fields are captured once; the request side may change freely after.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      id_q   <= '0;
      size_q <= '0;
    end else if (accept) begin
      base_q <= eol_addr;
      id_q   <= req_id;
      size_q <= req_size;
    end
  end

  // Registered command port: one strobe per launched word.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pgm_start <= 1'b0;
      pgm_addr  <= '0;
      pgm_data  <= '0;
    end else begin
      pgm_start <= issue;
      if (issue) begin
        pgm_addr <= word_addr;
        pgm_data <= word_data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      new_eol <= '0;
    end else if (finish) begin
      new_eol <= base_q + ADDR_W'(META_WORDS) + ADDR_W'(size_q);
    end
  end

endmodule

// File: rtl/rec_append_seq_chk.sv
module rec_append_seq_chk #(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 32,
  parameter int GROUP_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              src_ready,
  input logic              pgm_start,
  input logic [ADDR_W-1:0] pgm_addr,
  input logic [DATA_W-1:0] pgm_data,
  input logic              pgm_done,
  input logic              swap_req,
  input logic              rec_done,
  input logic              rec_err
);
  localparam int NGRP = DATA_W / GROUP_W;

  logic              outstanding;
  logic              arm;
  logic              live;
  logic [ADDR_W-1:0] stat_addr;
  logic [DATA_W-1:0] stat_val;

  function automatic logic groups_ok(logic [DATA_W-1:0] old_w,
                                     logic [DATA_W-1:0] new_w);
    logic ok;
    ok = 1'b1;
    for (int g = 0; g < NGRP; g++) begin
      if (new_w[g*GROUP_W +: GROUP_W] != old_w[g*GROUP_W +: GROUP_W] &&
          new_w[g*GROUP_W +: GROUP_W] != '0)
        ok = 1'b0;
    end
    return ok;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outstanding <= 1'b0;
      arm         <= 1'b0;
      live        <= 1'b0;
      stat_addr   <= '0;
      stat_val    <= '0;
    end else begin
      if (pgm_start)     outstanding <= 1'b1;
      else if (pgm_done) outstanding <= 1'b0;
      if (req_valid && req_ready) arm <= 1'b1;
      if (pgm_start && arm) begin
        arm       <= 1'b0;
        live      <= 1'b1;
        stat_addr <= pgm_addr;
        stat_val  <= pgm_data;
      end else if (pgm_start && live && pgm_addr == stat_addr) begin
        stat_val <= pgm_data;
      end
    end
  end

  assert_busy_refuse_R1: assert property (@(posedge clk) disable iff (!rst_n)
    pgm_start |-> !req_ready);

  assert_swap_no_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    swap_req |-> (req_ready && !pgm_start));

  assert_group_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pgm_start && live && !arm && pgm_addr == stat_addr) |->
      groups_ok(stat_val, pgm_data));

  assert_start_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pgm_start |=> !pgm_start);

  assert_wait_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pgm_start |-> !outstanding);

  assert_src_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    src_ready |-> (!outstanding && !req_ready));

  assert_abort_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rec_err |=> !pgm_start);

  assert_done_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rec_done |-> (!rec_err && req_ready));

endmodule

bind rec_append_seq rec_append_seq_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .GROUP_W(GROUP_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .src_ready(src_ready), .pgm_start(pgm_start), .pgm_addr(pgm_addr),
  .pgm_data(pgm_data), .pgm_done(pgm_done), .swap_req(swap_req),
  .rec_done(rec_done), .rec_err(rec_err)
);

// File: tb/rec_append_seq_tb.sv
module rec_append_seq_tb;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 32;
  localparam int ID_W   = 16;
  localparam int SIZE_W = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [ID_W-1:0]   req_id = '0;
  logic [SIZE_W-1:0] req_size = '0;
  logic [ADDR_W-1:0] eol_addr = '0;
  logic [ADDR_W-1:0] blk_limit = '0;
  logic              src_valid = 1'b0;
  logic              src_ready;
  logic [DATA_W-1:0] src_data = '0;
  logic              pgm_start;
  logic [ADDR_W-1:0] pgm_addr;
  logic [DATA_W-1:0] pgm_data;
  logic              pgm_done = 1'b0;
  logic              pgm_fail = 1'b0;
  logic              swap_req;
  logic              rec_done;
  logic              rec_err;
  logic [ADDR_W-1:0] new_eol;

  always #5 clk = ~clk;

  rec_append_seq u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_id(req_id), .req_size(req_size), .eol_addr(eol_addr),
    .blk_limit(blk_limit), .src_valid(src_valid), .src_ready(src_ready),
    .src_data(src_data), .pgm_start(pgm_start), .pgm_addr(pgm_addr),
    .pgm_data(pgm_data), .pgm_done(pgm_done), .pgm_fail(pgm_fail),
    .swap_req(swap_req), .rec_done(rec_done), .rec_err(rec_err),
    .new_eol(new_eol)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // Reference model state
  int          exp_addr_q[$];
  logic [31:0] exp_data_q[$];
  logic [31:0] rec_words[$];
  logic [31:0] src_q[$];
  logic [31:0] mem[int];
  int  writes_left = 0;
  bit  model_busy = 0;
  bit  pend_done = 0;
  bit  pend_err = 0;
  int  exp_eol = 0;
  bit  last_ready = 1;
  bit  last_src_ready = 0;
  bit  last_start = 0;
  bit  gap_mode = 0;
  int  gap_ctr = 0;
  int  lat = 1;
  int  fail_at = -1;
  int  wr_in_rec = 0;
  bit  port_busy = 0;
  int  port_cnt = 0;
  int  port_idx = 0;
  int  cyc = 0;

  function automatic bit group_rule(logic [31:0] o, logic [31:0] n);
    for (int g = 0; g < 2; g++)
      if (n[g*16 +: 16] != o[g*16 +: 16] && n[g*16 +: 16] != 16'h0) return 0;
    return 1;
  endfunction

  always @(negedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL R5 watchdog: actual %0d cycles expected below %0d", cyc, 100000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
    if (rst_n) begin
      // Outputs predicted at the previous negedge
      chk(rec_done == pend_done, "R8", "done pulse", rec_done, pend_done);
      if (pend_done) chk(new_eol == exp_eol[15:0], "R8", "new end of list", new_eol, exp_eol);
      chk(rec_err == pend_err, "R7", "error pulse", rec_err, pend_err);
      if (pend_done || pend_err) model_busy = 0;
      pend_done = 0;
      pend_err  = 0;

      // Acceptance of a request at the last rising edge
      if (req_valid && last_ready) begin
        bit fit;
        fit = (int'(eol_addr) + int'(req_size) + 2) <= int'(blk_limit);
        chk(swap_req == !fit, "R2", "swap request", swap_req, !fit);
        if (fit) begin
          model_busy = 1;
          wr_in_rec  = 0;
          exp_eol    = int'(eol_addr) + int'(req_size) + 2;
          exp_addr_q.push_back(int'(eol_addr));
          exp_data_q.push_back(32'h0000_FFFF);
          exp_addr_q.push_back(int'(eol_addr) + 1);
          exp_data_q.push_back({req_id, 8'h00, req_size});
          for (int i = 0; i < int'(req_size); i++) begin
            exp_addr_q.push_back(int'(eol_addr) + 2 + i);
            exp_data_q.push_back(rec_words[i]);
          end
          exp_addr_q.push_back(int'(eol_addr));
          exp_data_q.push_back(32'h0000_0000);
          writes_left = 3 + int'(req_size);
        end
      end else begin
        chk(swap_req == 1'b0, "R2", "no swap request", swap_req, 0);
      end
      chk(req_ready == !model_busy, "R1", "ready while busy/idle", req_ready, !model_busy);

      // Program port responder
      pgm_done = 0;
      pgm_fail = 0;
      begin
        bit pb0;
        pb0 = port_busy;
        if (port_busy) begin
          if (port_cnt <= 1) begin
            pgm_done  = 1;
            port_busy = 0;
            if (port_idx == fail_at) begin
              pgm_fail = 1;
              pend_err = 1;
              exp_addr_q.delete();
              exp_data_q.delete();
              src_q.delete();
              writes_left = 0;
            end else begin
              writes_left--;
              if (writes_left == 0) pend_done = 1;
            end
          end else begin
            port_cnt--;
          end
        end
        if (pgm_start) begin
          chk(!pb0, "R5", "start while port busy", pb0, 0);
          chk(!last_start, "R5", "start pulse width", last_start, 0);
          if (exp_addr_q.size() == 0) begin
            chk(0, "R1", "unexpected program command", pgm_addr, 0);
          end else begin
            int ea;
            logic [31:0] ed;
            logic [31:0] prev;
            ea = exp_addr_q.pop_front();
            ed = exp_data_q.pop_front();
            chk(pgm_addr == ea[15:0], "R3", "write address", pgm_addr, ea);
            if (ea == exp_eol - 2 - int'(rec_words.size()) || ed == 32'h0 || ed == 32'h0000_FFFF)
              chk(pgm_data == ed, "R4", "status/header value", pgm_data, ed);
            else
              chk(pgm_data == ed, "R3", "data value", pgm_data, ed);
            prev = mem.exists(int'(pgm_addr)) ? mem[int'(pgm_addr)] : 32'hFFFF_FFFF;
            if (prev != 32'hFFFF_FFFF)
              chk(group_rule(prev, pgm_data), "R4", "whole-group clear", pgm_data, prev);
            mem[int'(pgm_addr)] = pgm_data;
          end
          port_busy = 1;
          port_cnt  = lat;
          port_idx  = wr_in_rec;
          wr_in_rec++;
        end
      end
      last_start = pgm_start;

      // Data stream source
      if (src_valid && last_src_ready && src_q.size() > 0) void'(src_q.pop_front());
      gap_ctr++;
      src_valid = (src_q.size() > 0) && !(gap_mode && (gap_ctr % 3 == 0));
      src_data  = (src_q.size() > 0) ? src_q[0] : 32'h0;
    end
    last_src_ready = src_ready;
    last_ready     = req_ready;
  end

  task automatic do_rec(input int eol, input int limit, input int id,
                        input int size, input int l, input bit gaps,
                        input int fat, input bit poke);
    @(negedge clk); #1;
    lat = l;
    gap_mode = gaps;
    fail_at = fat;
    rec_words.delete();
    for (int i = 0; i < size; i++) begin
      logic [31:0] w;
      w = {id[15:0], 16'h0} ^ (32'h1357_9BDF * (i + 1));
      rec_words.push_back(w);
      src_q.push_back(w);
    end
    req_valid = 1;
    req_id    = id[15:0];
    req_size  = size[7:0];
    eol_addr  = eol[15:0];
    blk_limit = limit[15:0];
    @(negedge clk); #1;
    req_valid = 0;
    for (int k = 0; k < 2000; k++) begin
      if (!model_busy && !pend_done && !pend_err && !port_busy) break;
      @(negedge clk); #1;
      if (poke) begin
        req_valid = !req_ready;
        req_id    = 16'hDEAD;
        req_size  = 8'd1;
        eol_addr  = 16'h0F00;
        blk_limit = 16'hFFFF;
      end
    end
    req_valid = 0;
    src_q.delete();
    fail_at = -1;
    @(negedge clk); #1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1, "R1", "reset ready", req_ready, 1);
    chk(pgm_start == 1'b0, "R5", "reset start", pgm_start, 0);
    chk(swap_req == 1'b0, "R2", "reset swap", swap_req, 0);
    chk(rec_done == 1'b0, "R8", "reset done", rec_done, 0);
    #1 rst_n = 1;
    // R3 R8: three data words, fast port
    do_rec(16'h10, 16'h100, 16'h1234, 3, 1, 0, -1, 0);
    // R9: zero data words, slow port
    do_rec(16'h20, 16'h100, 16'h0042, 0, 3, 0, -1, 0);
    // R6 R1: stream gaps and requests held while busy
    do_rec(16'h30, 16'h100, 16'hBEEF, 5, 2, 1, -1, 1);
    // R2: exact fit writes
    do_rec(16'h40, 16'h46, 16'h0007, 4, 1, 0, -1, 0);
    // R2: one word short asks for a swap
    do_rec(16'h60, 16'h65, 16'h0008, 4, 1, 0, -1, 0);
    // R2: end of list already past the limit
    do_rec(16'h90, 16'h80, 16'h0009, 0, 1, 0, -1, 0);
    // R7: failure on the identifier/length write
    do_rec(16'h50, 16'h100, 16'h0A0A, 2, 1, 0, 1, 0);
    // R7: failure on the final status write
    do_rec(16'h58, 16'h100, 16'h0B0B, 2, 2, 1, 4, 0);
    // R8: clean record after an abort
    do_rec(16'h70, 16'h100, 16'h0C0C, 2, 1, 0, -1, 0);
    chk(exp_addr_q.size() == 0, "R3", "all writes seen", exp_addr_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule